// File: doc/BRIEF.md
# Trimmed-Carry Fractional Rate Generator

This block is a binary phase accumulator of `2^W` states that produces pulses at a rational fraction of its clock. The fraction does not have to have a power-of-two denominator. It adds a step value every cycle and emits a one-cycle carry pulse whenever the running sum passes the top of the range.

On the cycle after a carry, it adds the step plus a trim value. This is how a rate such as 12/1021 is reached exactly with a 10-bit register. With step 12 and trim 3, every 1021 cycles contain exactly 12 carries, and the phase word repeats with that period. Because the phase sequence repeats exactly, the output has no slow wander.

A second trim can be applied on the cycle after the phase's top bit rises without a carry. This lets the two halves of each output period each get their own correction, so the square output moves closer to even duty.

All inputs are plain control levels, sampled on every clock edge. The block has no data stream and no back-pressure. Choosing the step and trim values for a target fraction is left to the user. The user must keep `step + trim` and `step + mid_trim` below `2^W`.

Top module: `fracrate_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `phase_o` is 0 and `carry_o` is 0.
- R2: When `carry_o` is low and no mid-trim is pending, the next `phase_o` equals (`phase_o + step_i`) mod 2^W.
- R3: When `carry_o` is high, the next `phase_o` equals (`phase_o + step_i + trim_i`) mod 2^W.
- R4: `carry_o` is high for exactly one cycle after each addition whose full sum reached 2^W. When `carry_o` is low, `phase_o` did not decrease.
- R5: A mid-trim is pending in a cycle when `carry_o` is low, `phase_o` bit W-1 is 1, and that bit was 0 in the previous cycle. In that cycle, the next `phase_o` equals (`phase_o + step_i + mid_trim_i`) mod 2^W.
- R6: With W=10, step 12, trim 3 and mid-trim 0, the steady-state phase repeats every 1021 cycles. Each 1021-cycle window contains exactly 12 `carry_o` pulses.
- R7: `sq_o` equals bit W-1 of `phase_o`. With `mid_trim_i` 0, the mid-trim path has no effect on the sequence.
- R8: A change of `step_i`, `trim_i` or `mid_trim_i` takes effect on the very next addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | W | Normal increment |
| trim_i | input | W | Extra increment on the cycle after a carry |
| mid_trim_i | input | W | Extra increment on the cycle after a top-bit rise without carry |
| phase_o | output | W | Phase word |
| carry_o | output | 1 | One-cycle carry pulse |
| sq_o | output | 1 | Square output (phase top bit) |

## Verification
The hardest state to reach from the ports is a mid-trim cycle that coincides with a carry-heavy pattern: a large step that carries on nearly every cycle, while the top bit still rises now and then without a carry. Random runs mix large steps with large trims and change the inputs in mid-sequence to reach it. A directed run with the 12/1021 settings warms up first and then checks exact repetition and the carry count over one period.

// File: rtl/fracrate_pkg.sv
package fracrate_pkg;
  // Which correction the next addition receives.
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_WRAP = 2'd1,
    TRIM_MID  = 2'd2
  } trim_kind_e;
endpackage

// File: rtl/fracrate_incr_sel.sv
module fracrate_incr_sel
  import fracrate_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] trim_i,
  input  logic [W-1:0] mid_trim_i,
  input  logic         wrap_pend_i,
  input  logic         mid_pend_i,
  output logic [W:0]   incr_o,
  output trim_kind_e   kind_o
);
  localparam int IW = W + 1;

  logic [IW-1:0] extra;

  // A carry and a mid crossing never come from the same addition,
  // but the carry is given priority so that the choice is always defined.
  always_comb begin
    if (wrap_pend_i)     kind_o = TRIM_WRAP;
    else if (mid_pend_i) kind_o = TRIM_MID;
    else                 kind_o = TRIM_NONE;
  end

  always_comb begin
    unique case (kind_o)
      TRIM_WRAP: extra = {1'b0, trim_i};
      TRIM_MID:  extra = {1'b0, mid_trim_i};
      default:   extra = '0;
    endcase
  end

  assign incr_o = {1'b0, step_i} + extra;
endmodule

// File: rtl/fracrate_adder.sv
module fracrate_adder #(
  parameter int W = 10
) (
  input  logic [W-1:0] phase_i,
  input  logic [W:0]   incr_i,
  output logic [W-1:0] next_o,
  output logic         carry_o,
  output logic         mid_rise_o
);
  localparam int SW = W + 2;

  logic [SW-1:0] sum;

  assign sum        = {2'b00, phase_i} + {1'b0, incr_i};
  assign next_o     = sum[W-1:0];
  assign carry_o    = |sum[SW-1:W];
  // Top bit rises without passing the range boundary.
  assign mid_rise_o = !carry_o && !phase_i[W-1] && sum[W-1];
endmodule

// File: rtl/fracrate_state.sv
module fracrate_state #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] next_i,
  input  logic         carry_i,
  input  logic         mid_rise_i,
  output logic [W-1:0] phase_o,
  output logic         wrap_pend_o,
  output logic         mid_pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_o     <= '0;
      wrap_pend_o <= 1'b0;
      mid_pend_o  <= 1'b0;
    end else begin
      phase_o     <= next_i;
      wrap_pend_o <= carry_i;
      mid_pend_o  <= mid_rise_i;
    end
  end
endmodule

// File: rtl/fracrate_top.sv
module fracrate_top
  import fracrate_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] trim_i,
  input  logic [W-1:0] mid_trim_i,
  output logic [W-1:0] phase_o,
  output logic         carry_o,
  output logic         sq_o
);
  logic [W:0]   incr;
  trim_kind_e   kind;
  logic [W-1:0] phase_q;
  logic [W-1:0] phase_d;
  logic         carry_d;
  logic         mid_d;
  logic         wrap_pend_q;
  logic         mid_pend_q;

  fracrate_incr_sel #(.W(W)) u_sel (
    .step_i      (step_i),
    .trim_i      (trim_i),
    .mid_trim_i  (mid_trim_i),
    .wrap_pend_i (wrap_pend_q),
    .mid_pend_i  (mid_pend_q),
    .incr_o      (incr),
    .kind_o      (kind)
  );

  fracrate_adder #(.W(W)) u_add (
    .phase_i    (phase_q),
    .incr_i     (incr),
    .next_o     (phase_d),
    .carry_o    (carry_d),
    .mid_rise_o (mid_d)
  );

  fracrate_state #(.W(W)) u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_i      (phase_d),
    .carry_i     (carry_d),
    .mid_rise_i  (mid_d),
    .phase_o     (phase_q),
    .wrap_pend_o (wrap_pend_q),
    .mid_pend_o  (mid_pend_q)
  );

  assign phase_o = phase_q;
  assign carry_o = wrap_pend_q;
  assign sq_o    = phase_q[W-1];
endmodule

// File: rtl/fracrate_checker.sv
module fracrate_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] step_i,
  input logic [W-1:0] trim_i,
  input logic [W-1:0] mid_trim_i,
  input logic [W-1:0] phase_o,
  input logic         carry_o,
  input logic         mid_pend
);
  // R2
  a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_o && !mid_pend) |=>
      phase_o == W'($past(phase_o) + $past(step_i)));

  // R3
  a_r3_wrap_trim: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=>
      phase_o == W'($past(phase_o) + $past(step_i) + $past(trim_i)));

  // R4
  a_r4_no_carry_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_o |-> phase_o >= $past(phase_o));

  // R5
  a_r5_mid_trim: assert property (@(posedge clk) disable iff (!rst_n)
    mid_pend |=>
      phase_o == W'($past(phase_o) + $past(step_i) + $past(mid_trim_i)));
endmodule

bind fracrate_top fracrate_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .trim_i     (trim_i),
  .mid_trim_i (mid_trim_i),
  .phase_o    (phase_o),
  .carry_o    (carry_o),
  .mid_pend   (mid_pend_q)
);

// File: tb/fracrate_top_tb_top.sv
module fracrate_top_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] step_i = '0;
  logic [W-1:0] trim_i = '0;
  logic [W-1:0] mid_trim_i = '0;
  logic [W-1:0] phase_o;
  logic         carry_o;
  logic         sq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_phase;
  logic         m_wrap;
  logic         m_mid;

  always #5 clk = ~clk;

  fracrate_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .trim_i(trim_i),
    .mid_trim_i(mid_trim_i), .phase_o(phase_o), .carry_o(carry_o), .sq_o(sq_o)
  );

  function automatic logic [W+1:0] model_sum(logic [W-1:0] ph, logic [W-1:0] st,
                                             logic [W-1:0] add);
    return {2'b00, ph} + {2'b00, st} + {2'b00, add};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: model follows requirements R2-R5, R8; compare on the falling edge.
  task automatic tick(bit cmp);
    logic [W+1:0] s;
    logic [W-1:0] add;
    @(posedge clk);
    add = m_wrap ? trim_i : (m_mid ? mid_trim_i : '0);
    s = model_sum(m_phase, step_i, add);
    m_mid   = !(|s[W+1:W]) && !m_phase[W-1] && s[W-1];
    m_wrap  = |s[W+1:W];
    m_phase = s[W-1:0];
    @(negedge clk);
    if (cmp) begin
      check("R2/R3/R5 phase", 32'(phase_o), 32'(m_phase));
      check("R4 carry", 32'(carry_o), 32'(m_wrap));
      check("R7 sq", 32'(sq_o), 32'(phase_o[W-1]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 phase in reset", 32'(phase_o), 0);
    check("R1 carry in reset", 32'(carry_o), 0);
    rst_n = 1'b1;
    m_phase = '0; m_wrap = 1'b0; m_mid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));

    // R1: reset and first cycle after release with zero step
    step_i = 0;
    do_reset();
    tick(1);
    check("R1 first cycle phase", 32'(phase_o), 0);

    // R2: directed plain stepping
    step_i = 10'd100;
    for (int i = 0; i < 20; i++) tick(1);

    // R6: 12/1021 periodicity in steady state, mid-trim zero (R7)
    do_reset();
    step_i = 10'd12; trim_i = 10'd3; mid_trim_i = 10'd0;
    for (int i = 0; i < 2100; i++) tick(1);
    begin
      logic [W-1:0] start_ph;
      int wraps;
      start_ph = phase_o;
      wraps = 0;
      for (int i = 0; i < 1021; i++) begin
        tick(1);
        if (carry_o) wraps++;
      end
      check("R6 phase repeats after 1021", 32'(phase_o), 32'(start_ph));
      check("R6 carries per period", wraps, 12);
    end

    // R3/R4: large step carrying on most cycles
    step_i = 10'd1000; trim_i = 10'd20; mid_trim_i = 10'd0;
    for (int i = 0; i < 40; i++) tick(1);

    // R5: mid-trim directed
    do_reset();
    step_i = 10'd60; trim_i = 10'd5; mid_trim_i = 10'd9;
    for (int i = 0; i < 200; i++) tick(1);

    // R8 and random mix: inputs change mid-sequence
    for (int blk = 0; blk < 60; blk++) begin
      step_i     = W'($urandom_range(1, 700));
      trim_i     = W'($urandom_range(0, 1023 - step_i));
      mid_trim_i = W'($urandom_range(0, 1023 - step_i));
      for (int i = 0; i < 37; i++) tick(1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule